// File: doc/BRIEF.md
# USB Host Bus Power-State Sequencer

This block controls the power state of a USB host port from three software control bits: suspend, resume and reset. While the port runs, it enables the transaction scheduler, the frame counter and start-of-frame generation. A suspend request does not take effect until the transaction in flight has finished. After that, all three enables drop and stay low. Only a resume or a reset brings the port back. While the resume bit or the reset bit is set, the block selects the matching signaling on the bus. When software releases the bit, the scheduler, frame counter and start-of-frame generation start again.

The length of each resume or reset interval is a software obligation. The block measures each interval in clock cycles and raises a status flag when the interval was shorter than a parameterised minimum (20 ms worth of cycles by default). While the port is suspended, the block also watches the line for the attached device's wake-up signaling and raises a one-cycle interrupt when it begins. Line-level encoding belongs to the bus driver that consumes the signaling select.

Top module: `usb_host_pwr_seq`

## Requirements
- R1: After reset: `sched_en`, `frame_en` and `sof_en` are 1, `bus_sig` is 0 (idle), `wake_irq` is 0 and `short_hold` is 0.
- R2: If the port is running and `ctl_suspend` is sampled at 1 with `xfer_busy` at 0 (and `ctl_resume` and `ctl_reset` at 0), all three enables are 0 from the next clock edge.
- R3: If `ctl_suspend` is sampled while `xfer_busy` is 1, the enables stay 1 on every edge at which `xfer_busy` is still 1. They fall at the edge that first samples `xfer_busy` at 0.
- R4: While suspended, the enables stay 0 and `bus_sig` stays idle, even after `ctl_suspend` is cleared, until `ctl_resume` or `ctl_reset` is set.
- R5: From the edge that samples `ctl_resume` at 1, `bus_sig` is 1 (resume) and the enables are 0. After the edge that samples it at 0 again, `bus_sig` is 0 and the enables are 1.
- R6: From the edge that samples `ctl_reset` at 1, `bus_sig` is 2 (reset) and the enables are 0. After the edge that samples it at 0 again, `bus_sig` is 0 and the enables are 1.
- R7: When several control bits are set together, reset wins over resume and resume wins over suspend.
- R8: A 0-to-1 change of `wake_line`, sampled while the port is suspended, produces `wake_irq` = 1 for exactly one cycle after that edge. A rise at any other time produces no pulse.
- R9: When a resume or reset interval of N cycles (the cycles during which `bus_sig` is non-idle) ends, `short_hold` becomes (N < HOLD_CYC) at the ending edge. It keeps that value until the next interval ends.
- R10: If `ctl_suspend` is cleared while the block is still waiting for `xfer_busy` to fall, the port stays running and the enables never drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_suspend | input | 1 | Software suspend request |
| ctl_resume | input | 1 | Software resume request; resume signaling while set |
| ctl_reset | input | 1 | Software bus reset request; reset signaling while set |
| xfer_busy | input | 1 | A transaction is in flight |
| wake_line | input | 1 | Line shows wake-up signaling from the device |
| sched_en | output | 1 | Transaction scheduler enable |
| frame_en | output | 1 | Frame counter enable |
| sof_en | output | 1 | Start-of-frame generation enable |
| bus_sig | output | 2 | Bus signaling select: 0 idle, 1 resume, 2 reset |
| wake_irq | output | 1 | One-cycle remote wake-up interrupt |
| short_hold | output | 1 | Last resume/reset interval was shorter than HOLD_CYC |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `wake_line` is already synchronised and free of glitches, since the wake detector keys on a single-cycle edge. The bench changes every input only on the falling clock edge and holds it for whole cycles, so each rising edge sees stable values. The bench returns to the running state by a short reset pulse before each case. Every case therefore starts from a known state without relying on an earlier one.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [1:0] {
    SIG_IDLE   = 2'd0,
    SIG_RESUME = 2'd1,
    SIG_RESET  = 2'd2
  } bus_sig_e;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_DRAIN = 3'd1,
    ST_SUSP  = 3'd2,
    ST_RSM   = 3'd3,
    ST_RST   = 3'd4
  } pwr_state_e;

  // Next power state; reset beats resume, resume beats suspend.
  function automatic pwr_state_e next_state(pwr_state_e cur, logic sus,
                                            logic rsm, logic rst, logic busy);
    if (rst) return ST_RST;
    if (rsm) return ST_RSM;
    case (cur)
      ST_RUN, ST_DRAIN: return sus ? (busy ? ST_DRAIN : ST_SUSP) : ST_RUN;
      ST_SUSP:          return ST_SUSP;
      default:          return ST_RUN;
    endcase
  endfunction

  // Interval length is edges counted inside the interval plus the entry cycle.
  function automatic logic is_short(int unsigned edges_seen, int unsigned hold);
    return (edges_seen + 1) < hold;
  endfunction

  function automatic logic is_hold(pwr_state_e s);
    return (s == ST_RSM) || (s == ST_RST);
  endfunction

endpackage

// File: rtl/hps_state_ctl.sv
module hps_state_ctl
  import hps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_suspend,
  input  logic       ctl_resume,
  input  logic       ctl_reset,
  input  logic       xfer_busy,
  output pwr_state_e state,
  output logic       hold_active,
  output logic       hold_end
);

  pwr_state_e nxt;

  always_comb nxt = next_state(state, ctl_suspend, ctl_resume, ctl_reset, xfer_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

  assign hold_active = is_hold(state);
  assign hold_end    = hold_active && (nxt != state);

  AST_SUSP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP && !ctl_resume && !ctl_reset) |=> (state == ST_SUSP)); // R4

  AST_DRAIN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && xfer_busy && ctl_suspend && !ctl_resume && !ctl_reset)
      |=> (state == ST_DRAIN)); // R3

endmodule

// File: rtl/hps_hold_timer.sv
module hps_hold_timer
  import hps_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 1_200_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_active,
  input  logic hold_end,
  output logic short_hold
);

  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(HOLD_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!hold_active || hold_end) cnt <= '0;
    else if (cnt != CMAX)            cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        short_hold <= 1'b0;
    else if (hold_end) short_hold <= is_short(32'(cnt), HOLD_CYC);
  end

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_end |=> $stable(short_hold)); // R9

endmodule

// File: rtl/hps_wake_det.sv
module hps_wake_det (
  input  logic clk,
  input  logic rst_n,
  input  logic suspended,
  input  logic wake_line,
  output logic wake_irq
);

  logic wake_q;
  logic wake_rise;

  assign wake_rise = wake_line && !wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q   <= 1'b0;
      wake_irq <= 1'b0;
    end else begin
      wake_q   <= wake_line;
      wake_irq <= suspended && wake_rise;
    end
  end

  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq); // R8

  AST_WAKE_ONLY_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    !suspended |=> !wake_irq); // R8

endmodule

// File: rtl/usb_host_pwr_seq.sv
module usb_host_pwr_seq
  import hps_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 1_200_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_suspend,
  input  logic       ctl_resume,
  input  logic       ctl_reset,
  input  logic       xfer_busy,
  input  logic       wake_line,
  output logic       sched_en,
  output logic       frame_en,
  output logic       sof_en,
  output logic [1:0] bus_sig,
  output logic       wake_irq,
  output logic       short_hold
);

  pwr_state_e state;
  logic       hold_active;
  logic       hold_end;
  logic       running;
  logic       suspended;

  hps_state_ctl u_ctl (
    .clk, .rst_n, .ctl_suspend, .ctl_resume, .ctl_reset, .xfer_busy,
    .state, .hold_active, .hold_end
  );

  hps_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk, .rst_n, .hold_active, .hold_end, .short_hold
  );

  assign suspended = (state == ST_SUSP);

  hps_wake_det u_wake (
    .clk, .rst_n, .suspended, .wake_line, .wake_irq
  );

  assign running  = (state == ST_RUN) || (state == ST_DRAIN);
  assign sched_en = running;
  assign frame_en = running;
  assign sof_en   = running;

  always_comb begin
    case (state)
      ST_RSM:  bus_sig = SIG_RESUME;
      ST_RST:  bus_sig = SIG_RESET;
      default: bus_sig = SIG_IDLE;
    endcase
  end

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> (bus_sig == SIG_RESET && !frame_en)); // R6

  AST_RESUME_OVER_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_resume && !ctl_reset) |=> (bus_sig == SIG_RESUME && !sched_en)); // R7

  AST_IDLE_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_en && ctl_suspend && !xfer_busy && !ctl_resume && !ctl_reset)
      |=> (!frame_en && !sof_en && bus_sig == SIG_IDLE)); // R2

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sig != SIG_IDLE && !ctl_resume && !ctl_reset) |=> (frame_en && sched_en)); // R5

endmodule

// File: tb/sim_usb_host_pwr_seq.sv
module sim_usb_host_pwr_seq;

  localparam int CLK_PER = 10;
  localparam int HOLD    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_suspend = 1'b0, ctl_resume = 1'b0, ctl_reset = 1'b0;
  logic xfer_busy = 1'b0, wake_line = 1'b0;
  logic sched_en, frame_en, sof_en, wake_irq, short_hold;
  logic [1:0] bus_sig;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  usb_host_pwr_seq #(.HOLD_CYC(HOLD)) u0 (
    .clk, .rst_n, .ctl_suspend, .ctl_resume, .ctl_reset, .xfer_busy,
    .wake_line, .sched_en, .frame_en, .sof_en, .bus_sig, .wake_irq, .short_hold
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // enables packed as {sched,frame,sof}
  function automatic int ens();
    return {29'd0, sched_en, frame_en, sof_en};
  endfunction

  task automatic to_run();
    ctl_suspend = 0; ctl_resume = 0; xfer_busy = 0;
    ctl_reset = 1; step();
    ctl_reset = 0; step();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 enables", ens(), 7);
    chk("R1 bus_sig", int'(bus_sig), 0);
    chk("R1 wake_irq", int'(wake_irq), 0);
    chk("R1 short_hold", int'(short_hold), 0);

    // R7 priority sweep over all control combinations, from running
    for (int c = 0; c < 8; c++) begin
      to_run();
      ctl_reset = c[2]; ctl_resume = c[1]; ctl_suspend = c[0];
      step();
      chk("R7 bus_sig", int'(bus_sig), c[2] ? 2 : (c[1] ? 1 : 0));
      chk("R7 enables", ens(), (c != 0) ? 0 : 7);
    end

    // R2/R3 drain sweep over busy lengths
    for (int b = 0; b < 6; b++) begin
      to_run();
      ctl_suspend = 1; xfer_busy = (b != 0);
      for (int i = 0; i < b; i++) begin
        step();
        chk("R3 enables held while busy", ens(), 7);
      end
      xfer_busy = 0;
      step();
      chk(b == 0 ? "R2 enables off" : "R3 enables off", ens(), 0);
    end

    // R4 suspend persists after clearing suspend bit
    ctl_suspend = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R4 enables", ens(), 0);
      chk("R4 bus_sig", int'(bus_sig), 0);
    end

    // R8 wake while suspended
    wake_line = 1; step();
    chk("R8 wake pulse", int'(wake_irq), 1);
    step();
    chk("R8 wake one cycle", int'(wake_irq), 0);
    wake_line = 0; step();
    // R8 no wake when running
    to_run();
    wake_line = 1; step();
    chk("R8 no wake when running", int'(wake_irq), 0);
    wake_line = 0; step();

    // R10 suspend withdrawn during drain
    to_run();
    ctl_suspend = 1; xfer_busy = 1; step();
    ctl_suspend = 0; step();
    chk("R10 enables", ens(), 7);
    xfer_busy = 0; step();
    chk("R10 still running", ens(), 7);

    // R5/R6/R9 interval sweeps
    for (int mode = 0; mode < 2; mode++) begin
      for (int k = 1; k <= 12; k++) begin
        to_run();
        if (mode == 0) begin
          ctl_suspend = 1; step();
          ctl_suspend = 0; ctl_resume = 1;
        end else begin
          ctl_reset = 1;
        end
        for (int i = 0; i < k; i++) begin
          step();
          chk(mode == 0 ? "R5 resume sig" : "R6 reset sig", int'(bus_sig), mode == 0 ? 1 : 2);
          chk(mode == 0 ? "R5 enables off" : "R6 enables off", ens(), 0);
        end
        ctl_resume = 0; ctl_reset = 0;
        step();
        chk(mode == 0 ? "R5 restart" : "R6 restart", ens(), 7);
        chk("R9 short_hold", int'(short_hold), (k < HOLD) ? 1 : 0);
        step();
        chk("R9 flag held", int'(short_hold), (k < HOLD) ? 1 : 0);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule